// File: doc/BRIEF.md
# Ethernet receive descriptor status generator

This block follows one received Ethernet frame while it is spread over fixed-size receive buffers, and for every buffer it closes it produces one descriptor: a 16-bit status word and a data-length value. Frame bytes arrive one per beat on a valid/ready stream. A beat carries start-of-frame and end-of-frame markers, and the end-of-frame beat also carries the residual-bit count and the CRC-check result. A beat with no data byte can instead report an overrun or a collision, which ends the frame at that point. The address-match result travels with the start-of-frame beat.

Descriptors leave on a second valid/ready stream that is held in a one-entry output register. A descriptor stays on the outputs, unchanged, until the consumer takes it. The input stream is ready only when that register is empty or is being emptied in the same cycle (`in_ready = !ds_valid || ds_ready`). This lets back-pressure from the descriptor side stall the byte stream directly. Configuration pins set promiscuous acceptance, short-frame reporting, the minimum and maximum frame lengths and the late-collision window. They are meant to change only between frames.

Status bits use MSB-first numbering (bit 0 = vector index 15). Vector indices used: Last [11], First [10], Miss [8], length violation [5], non-octet [4], short [3], CRC error [2], overrun [1], collision [0]; indices [15:12], [9], [7:6] are always zero.

Top module: `eth_rx_desc_status`

## Requirements
- R1: Status indices [15:12], [9] and [7:6] are zero in every descriptor, and each flag appears only at its index listed above.
- R2: First ([10]) is set only on the descriptor of the buffer that received the frame's first byte.
- R3: A descriptor without Last has length BUF_BYTES and has no bit other than First set. It is emitted when a buffer fills and the frame has not ended.
- R4: Last ([11]) is set on the buffer that closes a frame, with length equal to the total octets counted (CRC bytes included). A frame that ends exactly on a buffer boundary closes that buffer as Last, with no extra empty descriptor.
- R5: A start-of-frame beat with no address match starts a frame only when promiscuous mode is on, and that frame's Last descriptor has Miss ([8]) set. Without promiscuous mode no descriptor is produced for it. A frame with an address match has Miss clear.
- R6: Bytes beyond cfg_max_len are not counted. The Last length saturates at cfg_max_len, and length violation ([5]) is set.
- R7: A nonzero residual-bit count at end of frame sets non-octet ([4]) and also forces CRC error ([2]).
- R8: A failed CRC check at end of frame sets CRC error ([2]).
- R9: Short ([3]) is set when the frame length is below cfg_min_len and short-frame reporting is enabled, and never otherwise.
- R10: An overrun beat during a frame closes it at once with Last and overrun ([1]) and the count so far. When overrun and collision arrive on the same beat, only overrun is reported.
- R11: A collision beat during a frame ends it. A Last descriptor with collision ([0]) is written only if the byte count has reached cfg_late_win or short-frame reporting is on; otherwise the frame is dropped with no further descriptor.
- R12: After reset ds_valid is 0. A descriptor held with ds_ready low stays stable, and in_ready equals !ds_valid || ds_ready.
- R13: Beats that arrive while no frame is open and that are not start-of-frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sof | input | 1 | Beat holds the frame's first byte |
| in_eof | input | 1 | Beat holds the frame's last byte |
| in_ovr | input | 1 | Abort beat: receive overrun (no data byte) |
| in_col | input | 1 | Abort beat: collision (no data byte) |
| in_resid | input | 3 | Residual bits after the last byte, valid with in_eof |
| in_crc_ok | input | 1 | CRC check passed, valid with in_eof |
| in_addr_hit | input | 1 | Address recognition matched, valid with in_sof |
| cfg_promisc | input | 1 | Accept frames without address match |
| cfg_short_rpt | input | 1 | Enable short-frame and early-collision reporting |
| cfg_min_len | input | LEN_W | Minimum frame length in octets |
| cfg_max_len | input | LEN_W | Maximum frame length in octets |
| cfg_late_win | input | LEN_W | Byte count from which a collision is late |
| ds_valid | output | 1 | Descriptor valid |
| ds_ready | input | 1 | Descriptor consumed |
| ds_status | output | 16 | Descriptor status word |
| ds_len | output | LEN_W | Descriptor data length |

## Verification
The bench builds the block with BUF_BYTES = 4 and LEN_W = 12, and sets the maximum length to 20, the minimum to 6 and the late-collision window to 8. A small buffer brings multi-buffer frames, frames ending exactly on a buffer boundary and overruns right after a buffer closes within a handful of bytes. A maximum of 20 makes truncation, with five full buffers followed by an empty Last buffer, cheap to reach. Collisions are placed on both sides of the window, and a back-pressure phase withholds ds_ready so that descriptors are held and the byte stream stalls.

// File: rtl/eth_rxd_pkg.sv
package eth_rxd_pkg;

  typedef struct packed {
    logic last;
    logic first;
    logic miss;
    logic len_viol;
    logic non_oct;
    logic short_f;
    logic crc_err;
    logic ovr;
    logic col;
  } rxd_flags_t;

  // MSB-first numbering: document bit n lands at vector index 15-n.
  function automatic logic [15:0] pack_status(rxd_flags_t f);
    logic [15:0] w;
    w       = '0;
    w[11]   = f.last;
    w[10]   = f.first;
    w[8]    = f.miss;
    w[5]    = f.len_viol;
    w[4]    = f.non_oct;
    w[3]    = f.short_f;
    w[2]    = f.crc_err;
    w[1]    = f.ovr;
    w[0]    = f.col;
    return w;
  endfunction

endpackage

// File: rtl/rxd_frame_tracker.sv
module rxd_frame_tracker
  import eth_rxd_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_ovr,
  input  logic             in_col,
  input  logic [2:0]       in_resid,
  input  logic             in_crc_ok,
  input  logic             in_addr_hit,
  input  logic             cfg_promisc,
  input  logic             cfg_short_rpt,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic [LEN_W-1:0] cfg_late_win,
  output logic             emit,
  output rxd_flags_t       emit_flags,
  output logic [LEN_W-1:0] emit_len
);
  localparam int               BUF_W    = $clog2(BUF_BYTES + 1);
  localparam logic [BUF_W-1:0] BUF_FULL = BUF_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] BUF_LEN  = LEN_W'(BUF_BYTES);

  logic             active_q, first_q, miss_q, trunc_q;
  logic [LEN_W-1:0] cnt_q;
  logic [BUF_W-1:0] buf_q;

  logic             active_d, first_d, miss_d, trunc_d;
  logic [LEN_W-1:0] cnt_d;
  logic [BUF_W-1:0] buf_d;

  logic             fire, abort, accept, take, room, late;
  logic             cur_first, cur_miss, cur_trunc, non_oct;
  logic [LEN_W-1:0] cur_cnt, new_cnt;
  logic [BUF_W-1:0] cur_buf, new_buf;

  assign fire    = in_valid & in_ready;
  assign abort   = in_ovr | in_col;
  assign accept  = in_addr_hit | cfg_promisc;
  assign take    = in_sof ? accept : active_q;
  assign late    = cnt_q >= cfg_late_win;
  assign non_oct = in_resid != 3'd0;

  // A start-of-frame beat begins from a clean frame context.
  assign cur_cnt   = in_sof ? '0 : cnt_q;
  assign cur_buf   = in_sof ? '0 : buf_q;
  assign cur_first = in_sof ? 1'b1 : first_q;
  assign cur_miss  = in_sof ? ~in_addr_hit : miss_q;
  assign cur_trunc = in_sof ? 1'b0 : trunc_q;

  assign room    = cur_cnt < cfg_max_len;
  assign new_cnt = room ? cur_cnt + LEN_W'(1) : cur_cnt;
  assign new_buf = room ? cur_buf + BUF_W'(1) : cur_buf;

  always_comb begin
    active_d   = active_q;
    first_d    = first_q;
    miss_d     = miss_q;
    trunc_d    = trunc_q;
    cnt_d      = cnt_q;
    buf_d      = buf_q;
    emit       = 1'b0;
    emit_flags = '0;
    emit_len   = '0;
    if (fire) begin
      if (abort) begin
        if (active_q) begin
          active_d = 1'b0;
          if (in_ovr) begin
            emit             = 1'b1;
            emit_flags.last  = 1'b1;
            emit_flags.first = first_q;
            emit_flags.miss  = miss_q;
            emit_flags.ovr   = 1'b1;
            emit_len         = cnt_q;
          end else if (late || cfg_short_rpt) begin
            emit             = 1'b1;
            emit_flags.last  = 1'b1;
            emit_flags.first = first_q;
            emit_flags.miss  = miss_q;
            emit_flags.col   = 1'b1;
            emit_len         = cnt_q;
          end
        end
      end else if (take) begin
        active_d = 1'b1;
        first_d  = cur_first;
        miss_d   = cur_miss;
        trunc_d  = cur_trunc | ~room;
        cnt_d    = new_cnt;
        buf_d    = new_buf;
        if (in_eof) begin
          active_d            = 1'b0;
          emit                = 1'b1;
          emit_flags.last     = 1'b1;
          emit_flags.first    = cur_first;
          emit_flags.miss     = cur_miss;
          emit_flags.len_viol = cur_trunc | ~room;
          emit_flags.non_oct  = non_oct;
          emit_flags.crc_err  = non_oct | ~in_crc_ok;
          emit_flags.short_f  = cfg_short_rpt & (new_cnt < cfg_min_len);
          emit_len            = new_cnt;
        end else if (new_buf == BUF_FULL) begin
          emit             = 1'b1;
          emit_flags.first = cur_first;
          emit_len         = BUF_LEN;
          first_d          = 1'b0;
          buf_d            = '0;
        end
      end else if (in_sof) begin
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      miss_q   <= 1'b0;
      trunc_q  <= 1'b0;
      cnt_q    <= '0;
      buf_q    <= '0;
    end else begin
      active_q <= active_d;
      first_q  <= first_d;
      miss_q   <= miss_d;
      trunc_q  <= trunc_d;
      cnt_q    <= cnt_d;
      buf_q    <= buf_d;
    end
  end

endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack
  import eth_rxd_pkg::*;
(
  input  rxd_flags_t  flags,
  output logic [15:0] status
);
  assign status = pack_status(flags);
endmodule

// File: rtl/rxd_desc_reg.sv
module rxd_desc_reg #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [15:0]      load_status,
  input  logic [LEN_W-1:0] load_len,
  input  logic             ds_ready,
  output logic             ds_valid,
  output logic [15:0]      ds_status,
  output logic [LEN_W-1:0] ds_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_valid  <= 1'b0;
      ds_status <= '0;
      ds_len    <= '0;
    end else if (load) begin
      ds_valid  <= 1'b1;
      ds_status <= load_status;
      ds_len    <= load_len;
    end else if (ds_ready) begin
      ds_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_rx_desc_status.sv
module eth_rx_desc_status
  import eth_rxd_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_ovr,
  input  logic             in_col,
  input  logic [2:0]       in_resid,
  input  logic             in_crc_ok,
  input  logic             in_addr_hit,
  input  logic             cfg_promisc,
  input  logic             cfg_short_rpt,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic [LEN_W-1:0] cfg_late_win,
  output logic             ds_valid,
  input  logic             ds_ready,
  output logic [15:0]      ds_status,
  output logic [LEN_W-1:0] ds_len
);
  logic             emit;
  rxd_flags_t       emit_flags;
  logic [LEN_W-1:0] emit_len;
  logic [15:0]      emit_status;

  assign in_ready = ~ds_valid | ds_ready;

  rxd_frame_tracker #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_ovr(in_ovr), .in_col(in_col),
    .in_resid(in_resid), .in_crc_ok(in_crc_ok), .in_addr_hit(in_addr_hit),
    .cfg_promisc(cfg_promisc), .cfg_short_rpt(cfg_short_rpt),
    .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
    .cfg_late_win(cfg_late_win),
    .emit(emit), .emit_flags(emit_flags), .emit_len(emit_len)
  );

  rxd_status_pack u_pack (
    .flags(emit_flags),
    .status(emit_status)
  );

  rxd_desc_reg #(.LEN_W(LEN_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(emit), .load_status(emit_status), .load_len(emit_len),
    .ds_ready(ds_ready),
    .ds_valid(ds_valid), .ds_status(ds_status), .ds_len(ds_len)
  );

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             ds_valid,
  input logic             ds_ready,
  input logic [15:0]      ds_status,
  input logic [LEN_W-1:0] ds_len,
  input logic [LEN_W-1:0] cfg_max_len
);
  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_status) && $stable(ds_len)));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |-> !in_ready);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (ds_status[15:12] == 4'd0 && !ds_status[9] && ds_status[7:6] == 2'd0));

  assert_mid_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_status[11]) |-> (ds_len == BUF_LEN && (ds_status & 16'hFBFF) == 16'd0));

  assert_nonoct_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_status[4]) |-> ds_status[2]);

  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_status[11]) |-> (ds_len <= cfg_max_len));

  assert_viol_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_status[5]) |-> (ds_len == cfg_max_len));

  assert_ovr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> !(ds_status[1] && ds_status[0]));

endmodule

bind eth_rx_desc_status rxd_checker #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_status(ds_status),
  .ds_len(ds_len), .cfg_max_len(cfg_max_len)
);

// File: tb/eth_rx_desc_status_bench.sv
`timescale 1ns/1ps
module eth_rx_desc_status_bench;
  localparam int LW  = 12;
  localparam int BUF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_ovr = 0, in_col = 0;
  logic [2:0] in_resid = 0;
  logic in_crc_ok = 1, in_addr_hit = 1;
  logic cfg_promisc = 0, cfg_short_rpt = 0;
  logic [LW-1:0] cfg_min_len = 6, cfg_max_len = 20, cfg_late_win = 8;
  logic ds_ready = 1;
  logic in_ready, ds_valid;
  logic [15:0] ds_status;
  logic [LW-1:0] ds_len;

  always #10 clk = ~clk;

  eth_rx_desc_status #(.LEN_W(LW), .BUF_BYTES(BUF)) u_eth_rx_desc_status (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_ovr(in_ovr), .in_col(in_col),
    .in_resid(in_resid), .in_crc_ok(in_crc_ok), .in_addr_hit(in_addr_hit),
    .cfg_promisc(cfg_promisc), .cfg_short_rpt(cfg_short_rpt),
    .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len), .cfg_late_win(cfg_late_win),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_status(ds_status), .ds_len(ds_len)
  );

  typedef struct { int st; int len; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit bp_mode = 0, last_fire = 0;
  string cur_tag = "R12";

  int m_act = 0, m_cnt = 0, m_buf = 0, m_first = 0, m_miss = 0, m_trunc = 0;

  function automatic int mk(int l, int f, int m, int lg, int no, int sh, int cr, int ov, int cl);
    return (l << 11) | (f << 10) | (m << 8) | (lg << 5) | (no << 4) | (sh << 3) | (cr << 2) | (ov << 1) | cl;
  endfunction

  function automatic void push(int st, int len);
    exp_t e;
    e.st = st; e.len = len;
    q.push_back(e);
  endfunction

  // Behavioural reference: consumes the beats the DUT accepts at this edge.
  always @(posedge clk) begin
    if (rst_n) begin
      if (ds_valid && ds_ready && q.size() > 0) void'(q.pop_front());
      last_fire = in_valid && in_ready;
      if (last_fire) begin
        if (in_ovr || in_col) begin
          if (m_act != 0) begin
            m_act = 0;
            if (in_ovr) push(mk(1, m_first, m_miss, 0, 0, 0, 0, 1, 0), m_cnt);
            else if (m_cnt >= int'(cfg_late_win) || cfg_short_rpt)
              push(mk(1, m_first, m_miss, 0, 0, 0, 0, 0, 1), m_cnt);
          end
        end else begin
          if (in_sof) begin
            if (in_addr_hit || cfg_promisc) begin
              m_act = 1; m_cnt = 0; m_buf = 0; m_first = 1; m_trunc = 0;
              m_miss = in_addr_hit ? 0 : 1;
            end else m_act = 0;
          end
          if (m_act != 0) begin
            if (m_cnt < int'(cfg_max_len)) begin m_cnt++; m_buf++; end
            else m_trunc = 1;
            if (in_eof) begin
              int no;
              no = (in_resid != 0) ? 1 : 0;
              push(mk(1, m_first, m_miss, m_trunc, no,
                      (cfg_short_rpt && m_cnt < int'(cfg_min_len)) ? 1 : 0,
                      (!in_crc_ok || no != 0) ? 1 : 0, 0, 0), m_cnt);
              m_act = 0;
            end else if (m_buf == BUF) begin
              push(mk(0, m_first, 0, 0, 0, 0, 0, 0, 0), BUF);
              m_first = 0; m_buf = 0;
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    ds_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = q.size() > 0;
      checks++;
      if (ds_valid !== ev) begin
        fails++;
        $display("FAIL %s: ds_valid=%0b expected %0b", cur_tag, ds_valid, ev);
      end
      if (ds_valid && ev) begin
        checks++;
        if (int'(ds_status) != q[0].st || int'(ds_len) != q[0].len) begin
          fails++;
          $display("FAIL %s: status=%04h len=%0d expected status=%04h len=%0d",
                   cur_tag, ds_status, ds_len, q[0].st[15:0], q[0].len);
        end
      end
      checks++;
      if (in_ready !== (!ds_valid || ds_ready)) begin
        fails++;
        $display("FAIL R12: in_ready=%0b expected %0b", in_ready, !ds_valid || ds_ready);
      end
    end
  end

  task automatic beat(input bit sof, input bit eof, input bit ovr, input bit col,
                      input int resid, input bit crc, input bit hit);
    in_valid = 1; in_sof = sof; in_eof = eof; in_ovr = ovr; in_col = col;
    in_resid = resid[2:0]; in_crc_ok = crc; in_addr_hit = hit;
    do begin @(posedge clk); #1; end while (!last_fire);
    in_valid = 0; in_sof = 0; in_eof = 0; in_ovr = 0; in_col = 0;
  endtask

  // kind: 0 normal end, 1 overrun, 2 collision, 3 both abort flags
  task automatic frame(input int n, input bit hit, input bit crc, input int resid, input int kind);
    for (int i = 0; i < n; i++)
      beat(i == 0, kind == 0 && i == n - 1, 0, 0, resid, crc, hit);
    if (kind != 0) beat(0, 0, kind == 1 || kind == 3, kind >= 2, 0, 1, hit);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((q.size() > 0 || ds_valid) && guard < 100) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (ds_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12: reset ds_valid=%0b in_ready=%0b expected 0 1", ds_valid, in_ready);
    end
    rst_n = 1;
    @(posedge clk); #1;

    cur_tag = "R2/R4 single buffer";   frame(3, 1, 1, 0, 0);  drain();
    cur_tag = "R3/R2 three buffers";   frame(10, 1, 1, 0, 0); drain();
    cur_tag = "R4 boundary end";       frame(8, 1, 1, 0, 0);  drain();
    cur_tag = "R8 crc error";          frame(7, 1, 0, 0, 0);  drain();
    cur_tag = "R7 non-octet";          frame(9, 1, 1, 3, 0);  drain();
    cur_tag = "R6 truncation";         frame(25, 1, 1, 0, 0); drain();
    cur_tag = "R1 field layout";       frame(5, 1, 0, 1, 0);  drain();
    cur_tag = "R13 idle beats";
    beat(0, 0, 0, 0, 0, 1, 1); beat(0, 1, 0, 0, 0, 1, 1); beat(0, 0, 1, 0, 0, 1, 1); drain();
    cur_tag = "R5 rejected no hit";    frame(6, 0, 1, 0, 0);  drain();
    cfg_promisc = 1;
    cur_tag = "R5 promisc miss";       frame(6, 0, 1, 0, 0);  drain();
    cur_tag = "R5 promisc hit";        frame(6, 1, 1, 0, 0);  drain();
    cfg_promisc = 0;
    cur_tag = "R10 overrun";           frame(5, 1, 1, 0, 1);  drain();
    cur_tag = "R10 overrun at edge";   frame(4, 1, 1, 0, 1);  drain();
    cur_tag = "R11 early collision";   frame(3, 1, 1, 0, 2);  drain();
    cur_tag = "R11 late collision";    frame(10, 1, 1, 0, 2); drain();
    cur_tag = "R10 ovr+col";           frame(6, 1, 1, 0, 3);  drain();
    cur_tag = "R9 no short report";    frame(4, 1, 1, 0, 0);  drain();
    cfg_short_rpt = 1;
    cur_tag = "R9 short frame";        frame(3, 1, 1, 0, 0);  drain();
    cur_tag = "R9 at minimum";         frame(6, 1, 1, 0, 0);  drain();
    cur_tag = "R11 early col reported"; frame(3, 1, 1, 0, 2); drain();
    cfg_short_rpt = 0;
    cur_tag = "R12 back-pressure";
    bp_mode = 1;
    frame(13, 1, 1, 0, 0);
    frame(9, 1, 0, 2, 0);
    frame(6, 1, 1, 0, 1);
    frame(2, 1, 1, 0, 0);
    drain();
    bp_mode = 0;
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule